// File: doc/BRIEF.md
# Replicated-Bank Two-Read Register File

This block is a 16-entry by 32-bit general register file with two read ports and one write port. It is built from two storage copies, and each copy has only one address port. Every register-file cycle is two ticks of the block clock long. The first tick is a read phase and the second tick is a write phase. During the read phase each copy is addressed on its own: copy A serves read port 0 and copy B serves read port 1. During the write phase both copies get the same address and the same data, so their contents never differ.

The read results are captured into output holding registers at the end of the read phase. Because of this, a write later in the same cycle cannot race through to the read outputs. A separate single-copy 16 x 32 scratch bank sits beside the general registers. It holds microcode temporaries and uses the same two-phase sequence, with its own read address, write enable, write address and write data.

A caller presents all addresses, enables and data while `rd_phase` is high and holds them for the whole two-tick cycle. The read results are valid from the tick after that and stay valid until the next read phase ends.

Top module: `dualread_regfile`

## Requirements
- R1: After reset all general and scratch entries read as zero, every output data bus is zero, and `rd_phase` is 1 (read phase).
- R2: The phase alternates on every clock: read phase (`rd_phase`=1), then write phase (`rd_phase`=0), then read phase again, and so on.
- R3: Read port 0 returns the general entry at `rd0_addr` and read port 1 returns the general entry at `rd1_addr`. The two addresses are independent of each other, and the results appear one clock after the read phase.
- R4: Both copies always hold identical contents, so equal read addresses give equal data on the two ports.
- R5: The read outputs change only at the end of a read phase and hold their value through the following write phase.
- R6: With `wr_en` high, `wr_data` is written to general entry `wr_addr` at the end of the write phase. If a read in the same cycle uses that address, it returns the old value, and the new value is visible from the next cycle.
- R7: With `wr_en` low, no general entry changes.
- R8: The scratch bank reads `tmp_rd_addr` and writes it under `tmp_wr_en` with the same phase timing as the general file. General and scratch writes never affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; two ticks per register-file cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_addr | input | 4 | Read port 0 address (copy A) |
| rd1_addr | input | 4 | Read port 1 address (copy B) |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write address |
| wr_data | input | 32 | General write data |
| tmp_rd_addr | input | 4 | Scratch bank read address |
| tmp_wr_en | input | 1 | Scratch write enable |
| tmp_wr_addr | input | 4 | Scratch write address |
| tmp_wr_data | input | 32 | Scratch write data |
| rd0_data | output | 32 | Held read data, port 0 |
| rd1_data | output | 32 | Held read data, port 1 |
| tmp_rd_data | output | 32 | Held read data, scratch bank |
| rd_phase | output | 1 | 1 during the read phase |

## Verification
The assertions check four things on every tick: that the phase alternates, that the held outputs stay stable through each write phase, that equal read addresses yield equal data from the two copies, and that an entry left unwritten keeps its value. Only the bench scenarios can show the rest: that each port returns the right entry across a full sweep of address pairs, that a same-cycle write is read as the old value and then as the new one, and that the scratch bank and the general file stay isolated from each other.

// File: rtl/dualread_regfile_pkg.sv
package dualread_regfile_pkg;
  typedef enum logic {PH_READ = 1'b0, PH_WRITE = 1'b1} phase_t;

  // Address seen by a single-port copy in a given phase.
  function automatic logic [7:0] port_addr(input phase_t ph,
                                           input logic [7:0] raddr,
                                           input logic [7:0] waddr);
    return (ph == PH_READ) ? raddr : waddr;
  endfunction

  function automatic phase_t phase_next(input phase_t ph);
    return (ph == PH_READ) ? PH_WRITE : PH_READ;
  endfunction
endpackage

// File: rtl/rf_phase_gen.sv
module rf_phase_gen
  import dualread_regfile_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_READ;
    else        phase <= phase_next(phase);
  end

  p_phase_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R7: an idle tick leaves the addressed entry unchanged
  p_idle_keeps_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (mem[$past(addr)] == $past(rdata)));
endmodule

// File: rtl/rf_hold_reg.sv
module rf_hold_reg
  import dualread_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (phase == PH_READ) q <= d;
  end

  p_hold_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE) |=> $stable(q));
endmodule

// File: rtl/dualread_regfile.sv
module dualread_regfile
  import dualread_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NCOPY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd0_addr,
  input  logic [ADDR_W-1:0] rd1_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] tmp_rd_addr,
  input  logic              tmp_wr_en,
  input  logic [ADDR_W-1:0] tmp_wr_addr,
  input  logic [DATA_W-1:0] tmp_wr_data,
  output logic [DATA_W-1:0] rd0_data,
  output logic [DATA_W-1:0] rd1_data,
  output logic [DATA_W-1:0] tmp_rd_data,
  output logic              rd_phase
);
  phase_t phase;
  logic   wr_strobe;
  logic   tmp_wr_strobe;
  logic [ADDR_W-1:0] rd_addr [NCOPY];
  logic [DATA_W-1:0] copy_q  [NCOPY];
  logic [DATA_W-1:0] held_q  [NCOPY];
  logic [ADDR_W-1:0] tmp_addr;
  logic [DATA_W-1:0] tmp_q;

  rf_phase_gen u_phase (.clk(clk), .rst_n(rst_n), .phase(phase));

  assign rd_phase      = (phase == PH_READ);
  assign wr_strobe     = wr_en & (phase == PH_WRITE);
  assign tmp_wr_strobe = tmp_wr_en & (phase == PH_WRITE);
  assign rd_addr[0]    = rd0_addr;
  assign rd_addr[1]    = rd1_addr;

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic [7:0] a8;
    logic [ADDR_W-1:0] a;
    assign a8 = port_addr(phase, 8'(rd_addr[c]), 8'(wr_addr));
    assign a  = a8[ADDR_W-1:0];

    rf_sp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(a), .we(wr_strobe),
      .wdata(wr_data), .rdata(copy_q[c]));

    rf_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .phase(phase), .d(copy_q[c]), .q(held_q[c]));
  end

  logic [7:0] tmp_a8;
  assign tmp_a8   = port_addr(phase, 8'(tmp_rd_addr), 8'(tmp_wr_addr));
  assign tmp_addr = tmp_a8[ADDR_W-1:0];

  rf_sp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tmp_bank (
    .clk(clk), .rst_n(rst_n), .addr(tmp_addr), .we(tmp_wr_strobe),
    .wdata(tmp_wr_data), .rdata(tmp_q));

  rf_hold_reg #(.DATA_W(DATA_W)) u_tmp_hold (
    .clk(clk), .rst_n(rst_n), .phase(phase), .d(tmp_q), .q(tmp_rd_data));

  assign rd0_data = held_q[0];
  assign rd1_data = held_q[1];

  // R4: the copies agree whenever both ports read one address
  p_copies_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && rd0_addr == rd1_addr) |=> (rd0_data == rd1_data));

  // R5: held outputs move only after a read-phase tick
  p_out_change_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_data != $past(rd0_data)) |-> ($past(phase) == PH_READ));
endmodule

// File: tb/dualread_regfile_bench.sv
module dualread_regfile_bench;
  localparam int DW = 32;
  localparam int N  = 16;

  logic clk = 0, rst_n = 0;
  logic [3:0] rd0_addr = 0, rd1_addr = 0, wr_addr = 0, tmp_rd_addr = 0, tmp_wr_addr = 0;
  logic wr_en = 0, tmp_wr_en = 0;
  logic [DW-1:0] wr_data = 0, tmp_wr_data = 0;
  logic [DW-1:0] rd0_data, rd1_data, tmp_rd_data;
  logic rd_phase;

  int checks = 0, errors = 0;
  logic [DW-1:0] gref [N];
  logic [DW-1:0] tref [N];

  always #5 clk = ~clk;

  dualread_regfile u_dualread_regfile (
    .clk(clk), .rst_n(rst_n), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmp_rd_addr(tmp_rd_addr), .tmp_wr_en(tmp_wr_en), .tmp_wr_addr(tmp_wr_addr),
    .tmp_wr_data(tmp_wr_data), .rd0_data(rd0_data), .rd1_data(rd1_data),
    .tmp_rd_data(tmp_rd_data), .rd_phase(rd_phase));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gpat(input int i, input int k);
    return (32'h9E37_79B9 * (i + 1)) ^ (k << 20);
  endfunction

  // One register-file cycle; called at a negedge with rd_phase high.
  task automatic cyc(input logic [3:0] a0, input logic [3:0] a1,
                     input logic we, input logic [3:0] wa, input logic [DW-1:0] wd,
                     input logic [3:0] ta, input logic twe, input logic [3:0] twa,
                     input logic [DW-1:0] twd, input string req);
    logic [DW-1:0] e0, e1, et;
    check({"R2 ", req}, {31'd0, rd_phase}, 32'd1);
    rd0_addr = a0; rd1_addr = a1; wr_en = we; wr_addr = wa; wr_data = wd;
    tmp_rd_addr = ta; tmp_wr_en = twe; tmp_wr_addr = twa; tmp_wr_data = twd;
    e0 = gref[a0]; e1 = gref[a1]; et = tref[ta];
    @(posedge clk); @(negedge clk);
    check({"R2 ", req}, {31'd0, rd_phase}, 32'd0);
    check({"R3 port0 ", req}, rd0_data, e0);
    check({"R3 port1 ", req}, rd1_data, e1);
    check({"R8 tmp ", req}, tmp_rd_data, et);
    @(posedge clk); @(negedge clk);
    check({"R5 hold0 ", req}, rd0_data, e0);
    check({"R5 hold1 ", req}, rd1_data, e1);
    if (we) gref[wa] = wd;
    if (twe) tref[twa] = twd;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin gref[i] = '0; tref[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 rd0", rd0_data, '0);
    check("R1 rd1", rd1_data, '0);
    check("R1 tmp", tmp_rd_data, '0);
    check("R1 phase", {31'd0, rd_phase}, 32'd1);
    for (int i = 0; i < N; i++)
      cyc(4'(i), 4'(N-1-i), 0, 0, 0, 4'(i), 0, 0, 0, "R1 zero sweep");
    // R6: fill general entries, each read at its own address in the same cycle
    for (int i = 0; i < N; i++)
      cyc(4'(i), 4'(i), 1, 4'(i), gpat(i, 1), 4'(i), 0, 0, 0, "R6 raw old");
    // R8: fill scratch bank; general reads unaffected
    for (int i = 0; i < N; i++)
      cyc(4'(i), 4'(i), 0, 0, 0, 4'(i), 1, 4'(i), ~gpat(i, 7), "R8 tmp fill");
    // R3/R4: every address pair
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        cyc(4'(a), 4'(b), 0, 0, 0, 4'(b), 0, 0, 0, "R3 R4 pair sweep");
    // R7: wr_en low with data presented changes nothing
    for (int i = 0; i < N; i++)
      cyc(4'(i), 4'(i), 0, 4'(i), 32'hDEAD_BEEF, 4'(i), 0, 4'(i), 32'hFEED_F00D, "R7 idle");
    for (int i = 0; i < N; i++)
      cyc(4'(i), 4'((i+5)%N), 0, 0, 0, 4'(i), 0, 0, 0, "R7 readback");
    // R6: overwrite while reading other/same addresses, then read new value
    for (int i = 0; i < N; i++) begin
      cyc(4'(i), 4'((i+1)%N), 1, 4'(i), gpat(i, 3), 4'(i), 1, 4'(i), gpat(i, 9), "R6 overwrite");
      cyc(4'(i), 4'(i), 0, 0, 0, 4'(i), 0, 0, 0, "R6 new visible");
    end
    // R8: scratch and general isolation readback
    for (int i = 0; i < N; i++)
      cyc(4'(N-1-i), 4'(i), 0, 0, 0, 4'(i), 0, 0, 0, "R8 isolation");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule